// File: doc/BRIEF.md
# Fast Fault Shutdown Controller

This block guards one inverter power stage against over-current. An external comparator produces a digital trip signal. When it asserts, the block disables the gate drivers in the same cycle through a combinational path, so turn-off never waits for a clock edge or for a synchronizer. The block then turns on an open-drain pull-down on the shared shutdown/fault pin. That pin also carries an external active-low shutdown request, so the pull-down signals the fault to the rest of the board.

The pull-down stays on until the block itself reads the pin as low. It is then released. The gates stay off until the external pull-up has recharged the pin and the block reads it as high again. The time the gates are disabled therefore covers the whole recharge of the external network, but the turn-off instant does not depend on that network. A low level driven onto the pin from outside, with no trip, also disables the gates.

The trip and the pin level are both asynchronous. Each passes through a `SYNC_STAGES`-deep synchronizer before it reaches the three-state controller (run, pulling, waiting for release). The gate-disable output also ORs in the raw inputs and every synchronizer stage. A trip pulse that lasts one clock period therefore leaves no gap in the disable. The block has no data stream, so it uses no valid/ready interface: every pin is plain control or status.

Top module: `smart_shutdown_ctrl`

## Requirements
- R1: After reset, with `trip_in` low and `pin_in` high, `pulldown_en` and `fault_flag` are 0 and `gate_off` is 0.
- R2: `gate_off` rises in the same cycle that `trip_in` rises, before any clock edge. Its turn-off delay does not depend on the pin's recharge timing.
- R3: A `trip_in` pulse at least one clock period long keeps `gate_off` at 1 in every cycle from the trip until recovery, with no gap.
- R4: `pulldown_en` (1 = pull-down on) and `fault_flag` both rise on the `SYNC_STAGES`+1-th rising clock edge after `trip_in` rises. `pulldown_en` is never 1 while `fault_flag` is 0.
- R5: `pulldown_en` stays 1 while the pin reads high. It falls on the `SYNC_STAGES`+1-th rising edge after `pin_in` falls.
- R6: After the pull-down is released, `gate_off` stays 1 while `pin_in` is low. `gate_off` and `fault_flag` both fall on the `SYNC_STAGES`+1-th rising edge after `pin_in` rises, provided no trip is pending.
- R7: The total disable time after a trip grows cycle for cycle with the pin's recharge time. A recharge that is N cycles longer gives a disable that is exactly N cycles longer.
- R8: With no trip, a low on `pin_in` sets `gate_off` at once and leaves `pulldown_en` and `fault_flag` at 0. `gate_off` clears on the `SYNC_STAGES`-th rising edge after `pin_in` returns high.
- R9: A new trip while the controller waits for the pin to recharge turns the pull-down back on. `pulldown_en` rises on the `SYNC_STAGES`+1-th rising edge after the new `trip_in` rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_in | input | 1 | Digitized over-current comparator output, asynchronous, 1 = trip |
| pin_in | input | 1 | Logic level read from the shutdown/fault pin, asynchronous, 0 = low |
| gate_off | output | 1 | 1 = force both gate drivers of every leg off |
| pulldown_en | output | 1 | 1 = turn on the open-drain pull-down of the shutdown/fault pin |
| fault_flag | output | 1 | 1 from the start of a pull-down episode until return to run |

## Verification
Most wrong internal states show up at the ports within a few clock edges. A controller stuck in the pulling state never releases `pulldown_en` once the pin is low. A controller that returns to run too early drops `gate_off` while the pin is still low. A synchronizer stage that is missing or stuck moves the `pulldown_en` and `gate_off` edges away from their fixed `SYNC_STAGES`+1 positions. A break in the combinational disable path shows in the very cycle of the trip, before any clock edge. A short trip that is lost in the synchronizer shows as a one-cycle gap in `gate_off`.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PULL = 2'd1,
    ST_HOLD = 2'd2
  } sdc_state_t;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic seen
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q    = chain[STAGES-1];
  // raw input or any stage: covers the synchronizer latency window
  assign seen = d | (|chain);

  // R3
  sync_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(d) |-> seen);
endmodule

// File: rtl/sdc_fsm.sv
module sdc_fsm
  import sdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_s,
  input  logic       pin_low_s,
  output sdc_state_t state,
  output logic       pulldown_en,
  output logic       fault_flag
);
  sdc_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:  if (trip_s) nxt = ST_PULL;
      ST_PULL: if (pin_low_s && !trip_s) nxt = ST_HOLD;
      ST_HOLD: begin
        if (trip_s)          nxt = ST_PULL;
        else if (!pin_low_s) nxt = ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      fault_flag <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_RUN && nxt == ST_PULL) fault_flag <= 1'b1;
      else if (nxt == ST_RUN)                fault_flag <= 1'b0;
    end
  end

  assign pulldown_en = (state == ST_PULL);

  // R4
  pull_on_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && trip_s) |=> (pulldown_en && fault_flag));
  // R4
  pull_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulldown_en |-> fault_flag);
  // R5
  release_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulldown_en) |-> $past(pin_low_s));
  // R6
  flag_clear_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_flag) |-> ($past(!pin_low_s) && $past(!trip_s)));
endmodule

// File: rtl/smart_shutdown_ctrl.sv
module smart_shutdown_ctrl
  import sdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_in,
  input  logic pin_in,
  output logic gate_off,
  output logic pulldown_en,
  output logic fault_flag
);
  logic       trip_s, trip_seen;
  logic       pin_low_s, pin_low_seen;
  sdc_state_t state;

  sdc_sync #(.STAGES(SYNC_STAGES)) u_trip_sync (
    .clk(clk), .rst_n(rst_n), .d(trip_in), .q(trip_s), .seen(trip_seen)
  );

  sdc_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(~pin_in), .q(pin_low_s), .seen(pin_low_seen)
  );

  sdc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .trip_s(trip_s), .pin_low_s(pin_low_s),
    .state(state), .pulldown_en(pulldown_en), .fault_flag(fault_flag)
  );

  // fast path: raw trip and raw pin level reach the gates without a clock
  assign gate_off = trip_seen | pin_low_seen | (state != ST_RUN);

  // R6
  flag_keeps_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> gate_off);
  // R8
  ext_low_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_flag && !trip_s) |=> !pulldown_en);
endmodule

// File: tb/smart_shutdown_ctrl_test.sv
module smart_shutdown_ctrl_test;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip_in = 1'b0;
  logic ext_low = 1'b0;
  logic pin_rc = 1'b1;
  logic pin_in;
  logic gate_off, pulldown_en, fault_flag;
  int   checks = 0;
  int   errors = 0;
  int   fall_d = 4;
  int   rise_d = 5;
  int   fall_cnt = 0;
  int   rise_cnt = 0;

  always #5 clk = ~clk;

  assign pin_in = pin_rc & ~ext_low;

  smart_shutdown_ctrl #(.SYNC_STAGES(NS)) uut (
    .clk(clk), .rst_n(rst_n), .trip_in(trip_in), .pin_in(pin_in),
    .gate_off(gate_off), .pulldown_en(pulldown_en), .fault_flag(fault_flag)
  );

  // RC-like pin model, updated on falling edges
  always @(negedge clk) begin
    if (pulldown_en) begin
      rise_cnt = 0;
      if (pin_rc) begin
        fall_cnt = fall_cnt + 1;
        if (fall_cnt >= fall_d) begin pin_rc = 1'b0; fall_cnt = 0; end
      end
    end else begin
      fall_cnt = 0;
      if (!pin_rc) begin
        rise_cnt = rise_cnt + 1;
        if (rise_cnt >= rise_d) begin pin_rc = 1'b1; rise_cnt = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wait_run(output int cyc);
    cyc = 0;
    while (gate_off && cyc < 500) begin tick(); cyc++; end
  endtask

  task automatic t_reset();
    chk(pulldown_en == 0, "R1 pulldown", pulldown_en, 0);
    chk(fault_flag == 0, "R1 flag", fault_flag, 0);
    chk(gate_off == 0, "R1 gate", gate_off, 0);
  endtask

  // full trip episode with edge timing, R2 R4 R5 R6
  task automatic t_trip_timing();
    int c;
    @(negedge clk); trip_in = 1'b1; #1;
    chk(gate_off == 1, "R2 same-cycle off", gate_off, 1);
    for (int i = 0; i < NS; i++) begin
      tick();
      chk(pulldown_en == 0, "R4 pulldown early", pulldown_en, 0);
    end
    tick();
    chk(pulldown_en == 1, "R4 pulldown on", pulldown_en, 1);
    chk(fault_flag == 1, "R4 flag on", fault_flag, 1);
    @(negedge clk); trip_in = 1'b0;
    c = 0;
    while (pin_in && c < 100) begin
      tick(); c++;
      if (pin_in) chk(pulldown_en == 1, "R5 held while high", pulldown_en, 1);
    end
    for (int i = 0; i < NS - 1; i++) tick();
    chk(pulldown_en == 1, "R5 still on before sync", pulldown_en, 1);
    tick();
    chk(pulldown_en == 0, "R5 released", pulldown_en, 0);
    chk(gate_off == 1, "R6 off while low", gate_off, 1);
    c = 0;
    while (!pin_in && c < 100) begin
      tick(); c++;
      chk(gate_off == 1, "R6 off while low", gate_off, 1);
    end
    for (int i = 0; i < NS - 1; i++) tick();
    chk(gate_off == 1, "R6 off before sync", gate_off, 1);
    chk(fault_flag == 1, "R6 flag before sync", fault_flag, 1);
    tick();
    chk(gate_off == 0, "R6 gates back on", gate_off, 0);
    chk(fault_flag == 0, "R6 flag cleared", fault_flag, 0);
  endtask

  // one-cycle trip pulse, R3
  task automatic t_short_pulse();
    int gaps = 0;
    @(negedge clk); trip_in = 1'b1;
    @(negedge clk); trip_in = 1'b0;
    for (int i = 0; i < NS + 1; i++) begin
      #1; if (!gate_off) gaps++;
      @(negedge clk);
    end
    chk(gaps == 0, "R3 no gap", gaps, 0);
    chk(fault_flag == 1, "R3 pulse captured", fault_flag, 1);
    gaps = 0;
    while (fault_flag) begin tick(); if (fault_flag && !gate_off) gaps++; end
    chk(gaps == 0, "R3 held to recovery", gaps, 0);
  endtask

  task automatic measure(input int rd, output int cyc);
    int c2;
    rise_d = rd;
    @(negedge clk); trip_in = 1'b1;
    @(negedge clk); trip_in = 1'b0;
    wait_run(c2);
    cyc = c2;
  endtask

  // R7
  task automatic t_disable_scaling();
    int a, b;
    measure(5, a);
    repeat (4) tick();
    measure(20, b);
    chk(b - a == 15, "R7 disable grows with recharge", b - a, 15);
    chk(a > 0, "R7 nonzero disable", a, 1);
    rise_d = 5;
  endtask

  // R8
  task automatic t_external_low();
    @(negedge clk); ext_low = 1'b1; #1;
    chk(gate_off == 1, "R8 immediate off", gate_off, 1);
    repeat (6) tick();
    chk(pulldown_en == 0, "R8 no pulldown", pulldown_en, 0);
    chk(fault_flag == 0, "R8 no flag", fault_flag, 0);
    chk(gate_off == 1, "R8 still off", gate_off, 1);
    @(negedge clk); ext_low = 1'b0;
    for (int i = 0; i < NS - 1; i++) tick();
    chk(gate_off == 1, "R8 off before sync", gate_off, 1);
    tick();
    chk(gate_off == 0, "R8 cleared", gate_off, 0);
  endtask

  // R9
  task automatic t_retrip();
    int c;
    rise_d = 30;
    @(negedge clk); trip_in = 1'b1;
    @(negedge clk); trip_in = 1'b0;
    c = 0;
    while (!pulldown_en && c < 50) begin tick(); c++; end
    while (pulldown_en && c < 100) begin tick(); c++; end
    repeat (3) tick();
    chk(pulldown_en == 0, "R9 waiting state", pulldown_en, 0);
    @(negedge clk); trip_in = 1'b1;
    for (int i = 0; i < NS; i++) begin
      tick();
      chk(pulldown_en == 0, "R9 pulldown early", pulldown_en, 0);
    end
    tick();
    chk(pulldown_en == 1, "R9 pulldown again", pulldown_en, 1);
    @(negedge clk); trip_in = 1'b0;
    wait_run(c);
    chk(gate_off == 0 && fault_flag == 0, "R9 recovers", gate_off, 0);
    rise_d = 5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    tick();
    t_reset();
    t_trip_timing();
    repeat (3) tick();
    t_short_pulse();
    repeat (3) tick();
    t_disable_scaling();
    repeat (3) tick();
    t_external_low();
    repeat (3) tick();
    t_retrip();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule